// File: doc/BRIEF.md
# SPI Master Register and FIFO Front End

This block is the software-facing half of an SPI master. A 32-bit register bus reads and writes a small set of setup registers (enable, clock, word format, frame), a FIFO control register, a status register and an interrupt group. Eight-word transmit and receive queues sit between the bus and a separate serial engine, which handles the pin timing. Both queues are reached through one data offset: a bus write feeds the transmit queue, and a bus read drains the receive queue.

The engine takes transmit words through a valid/take pair. It returns received words through a one-cycle strobe. The front end tracks three events: a receive queue that fills to a programmable level, a receive word lost because the queue was full, and a transmit-complete pulse from the engine. These events are held in sticky flags that software clears by writing ones. A single interrupt line is the OR of the enabled flags.

Top module: `spi_regfront`

## Requirements
- R1: After synchronous reset, every register reads zero, both queues are empty, `irq` is low, `eng_enable` is low and `eng_tx_valid` is low.
- R2: The setup registers read back what was written, masked to their implemented bits:
  - 0x04 keeps bits 14:12 and 7:0.
  - 0x08 keeps bits 13:0.
  - 0x0C keeps bits 5:0.
  - 0x10 keeps bits 15:14.
  - 0x18 keeps bits 4, 3 and 0.

  The `cfg_*` outputs carry these values. A read of an unmapped offset returns zero.
- R3: A bus write to 0x24 appends the word to the transmit queue. The engine receives the words in the order written. A write while 8 words are queued is dropped.
- R4: A bus read of 0x24 returns and removes the oldest received word. A read while the receive queue is empty returns zero.
- R5: Bit 0 of the status register (0x14) is 1 exactly when the receive queue holds at least one word.
- R6: In the FIFO control register (0x20), writing 1 to bit 12 empties the transmit queue and writing 1 to bit 4 empties the receive queue. Both bits read back as 0. Bits 11:8 (transmit level) and 3:0 (receive level) are stored and read back.
- R7: A read of 0x1C reports two receive-level indications:
  - Bit 9 is 1 while the receive level is nonzero and the queue holds at least that many words.
  - Bit 3 is a sticky flag. It is set when an accepted engine word brings the queue count up to exactly the nonzero receive level.
- R8: An engine word that arrives while the receive queue is full, with no bus read in the same cycle, is discarded. It sets the sticky flag at bit 0 of 0x1C.
- R9: A pulse on `eng_tx_done` sets the sticky flag at bit 4 of 0x1C.
- R10: Writing to 0x1C clears each flag whose bit (4, 3 or 0) is 1 in the written data. Zero bits leave flags unchanged. An event in the same cycle as its clear leaves the flag set.
- R11: `irq` is high exactly when some flag at bit 4, 3 or 0 of 0x1C is set and the same bit of 0x18 is 1.
- R12: Bit 0 of 0x00 drives `eng_enable`. `eng_tx_valid` is high only when enabled and the transmit queue is not empty. Clearing the enable leaves all setup registers and queue contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of 0x24 pops) |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during `bus_rd` |
| eng_enable | output | 1 | Serial engine run enable |
| eng_tx_valid | output | 1 | Transmit word available to the engine |
| eng_tx_word | output | 32 | Oldest transmit word |
| eng_tx_take | input | 1 | Engine consumes the transmit word |
| eng_rx_valid | input | 1 | Engine delivers a received word |
| eng_rx_word | input | 32 | Received word |
| eng_tx_done | input | 1 | Engine transmit-complete pulse |
| cfg_clock | output | 16 | Clock setup register |
| cfg_txword | output | 14 | Transmit word setup register |
| cfg_rxword | output | 6 | Receive word setup register |
| cfg_frame | output | 16 | Frame setup register |
| irq | output | 1 | Interrupt request |

## Verification
Two situations are hard to reach: a receive word that arrives against a full queue, and an event that coincides with a software clear of the same flag. The bench reaches the first by setting the receive level to zero and streaming nine engine words with no reads in between. It then drains the queue to show that exactly the ninth word went missing. It reaches the second by driving `eng_tx_done` and a clear write to 0x1C in the same clock cycle. Random data words and random setup values are mixed with these directed cases.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_CLOCK = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_TXW   = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_RXW   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_FRAME = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_IFLAG = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_FCTL  = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 6'h24;

    localparam logic [15:0] CLOCK_MASK = 16'h70FF;
    localparam logic [15:0] FRAME_MASK = 16'hC000;

    localparam int BIT_TXFLUSH = 12;
    localparam int BIT_RXFLUSH = 4;
    localparam int BIT_LEVEL   = 9;

    // sticky interrupt sources, one bit each
    typedef struct packed {
        logic tx_done;
        logic rx_cmp;
        logic rx_ovr;
    } irq_flags_t;

    // pull the three flag positions (4, 3, 0) out of a bus word
    function automatic irq_flags_t flags_from_word(logic [DATA_W-1:0] w);
        irq_flags_t f;
        f.tx_done = w[4];
        f.rx_cmp  = w[3];
        f.rx_ovr  = w[0];
        return f;
    endfunction

    // place the flags back at their bus positions
    function automatic logic [DATA_W-1:0] flags_to_word(irq_flags_t f, logic level);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_LEVEL] = level;
        w[4] = f.tx_done;
        w[3] = f.rx_cmp;
        w[0] = f.rx_ovr;
        return w;
    endfunction

endpackage

// File: rtl/spi_rf_fifo.sv
module spi_rf_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 pop_data,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full,
    output logic                         dropped
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH-1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign empty    = (count == '0);
    assign full     = (count == FULL_CNT);
    assign pop_ok   = pop && !empty;
    assign push_ok  = push && (!full || pop_ok);
    assign dropped  = push && !push_ok;
    assign pop_data = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush && !rst) mem[wr_ptr] <= push_data;
    end

    // R3
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst) count <= FULL_CNT);
    // R6
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst) flush |=> empty);
    // R8
    drop_keeps_full_chk: assert property (@(posedge clk) disable iff (rst)
        (dropped && !flush) |=> full);

endmodule

// File: rtl/spi_rf_irq.sv
module spi_rf_irq
    import spi_rf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  irq_flags_t set,
    input  irq_flags_t clr,
    input  irq_flags_t en,
    output irq_flags_t flags,
    output logic       irq
);
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= irq_flags_t'((flags & ~clr) | set);
    end

    assign irq = |(flags & en);

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        set.rx_ovr |=> flags.rx_ovr);
    // R10
    clear_works_chk: assert property (@(posedge clk) disable iff (rst)
        (clr.rx_cmp && !set.rx_cmp) |=> !flags.rx_cmp);
    // R7
    cmp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flags.rx_cmp && !clr.rx_cmp) |=> flags.rx_cmp);

endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
    import spi_rf_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int THR_W      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [5:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              eng_enable,
    output logic              eng_tx_valid,
    output logic [31:0]       eng_tx_word,
    input  logic              eng_tx_take,
    input  logic              eng_rx_valid,
    input  logic [31:0]       eng_rx_word,
    input  logic              eng_tx_done,
    output logic [15:0]       cfg_clock,
    output logic [13:0]       cfg_txword,
    output logic [5:0]        cfg_rxword,
    output logic [15:0]       cfg_frame,
    output logic              irq
);
    localparam int CW = $clog2(FIFO_DEPTH+1);

    logic             ctl_en;
    logic [THR_W-1:0] tx_thr, rx_thr;
    irq_flags_t       ien, flags, set_ev, clr_ev;

    logic          wr_at_data, rd_at_data, wr_fctl;
    logic          tx_flush, rx_flush;
    logic [31:0]   rx_head;
    logic [CW-1:0] tx_count, rx_count;
    logic          tx_empty, tx_full, tx_drop;
    logic          rx_empty, rx_full, rx_drop;
    logic          rx_pop, rx_accept, level_hit;

    assign wr_at_data = bus_wr && (bus_addr == OFS_DATA);
    assign rd_at_data = bus_rd && (bus_addr == OFS_DATA);
    assign wr_fctl    = bus_wr && (bus_addr == OFS_FCTL);
    assign tx_flush   = wr_fctl && bus_wdata[BIT_TXFLUSH];
    assign rx_flush   = wr_fctl && bus_wdata[BIT_RXFLUSH];

    // setup registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_en     <= 1'b0;
            cfg_clock  <= '0;
            cfg_txword <= '0;
            cfg_rxword <= '0;
            cfg_frame  <= '0;
            ien        <= '0;
            tx_thr     <= '0;
            rx_thr     <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_CTRL:  ctl_en     <= bus_wdata[0];
                OFS_CLOCK: cfg_clock  <= bus_wdata[15:0] & CLOCK_MASK;
                OFS_TXW:   cfg_txword <= bus_wdata[13:0];
                OFS_RXW:   cfg_rxword <= bus_wdata[5:0];
                OFS_FRAME: cfg_frame  <= bus_wdata[15:0] & FRAME_MASK;
                OFS_IEN:   ien        <= flags_from_word(bus_wdata);
                OFS_FCTL: begin
                    tx_thr <= bus_wdata[8 +: THR_W];
                    rx_thr <= bus_wdata[0 +: THR_W];
                end
                default: ;
            endcase
        end
    end

    spi_rf_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_txq (
        .clk(clk), .rst(rst), .flush(tx_flush),
        .push(wr_at_data), .push_data(bus_wdata),
        .pop(eng_tx_take && eng_tx_valid), .pop_data(eng_tx_word),
        .count(tx_count), .empty(tx_empty), .full(tx_full), .dropped(tx_drop)
    );

    assign rx_pop = rd_at_data;

    spi_rf_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_rxq (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(eng_rx_valid), .push_data(eng_rx_word),
        .pop(rx_pop), .pop_data(rx_head),
        .count(rx_count), .empty(rx_empty), .full(rx_full), .dropped(rx_drop)
    );

    assign eng_enable   = ctl_en;
    assign eng_tx_valid = ctl_en && !tx_empty;

    assign rx_accept = eng_rx_valid && !rx_drop && !rx_flush;
    assign level_hit = (rx_thr != '0) && (32'(rx_count) >= 32'(rx_thr));

    always_comb begin
        set_ev.tx_done = eng_tx_done;
        set_ev.rx_ovr  = rx_drop && !rx_flush;
        set_ev.rx_cmp  = rx_accept && !(rx_pop && !rx_empty)
                         && (32'(rx_count) + 1 == 32'(rx_thr));
        clr_ev = (bus_wr && bus_addr == OFS_IFLAG) ? flags_from_word(bus_wdata) : '0;
    end

    spi_rf_irq u_irq (
        .clk(clk), .rst(rst), .set(set_ev), .clr(clr_ev),
        .en(ien), .flags(flags), .irq(irq)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_CTRL:  bus_rdata = {31'b0, ctl_en};
                OFS_CLOCK: bus_rdata = {16'b0, cfg_clock};
                OFS_TXW:   bus_rdata = {18'b0, cfg_txword};
                OFS_RXW:   bus_rdata = {26'b0, cfg_rxword};
                OFS_FRAME: bus_rdata = {16'b0, cfg_frame};
                OFS_STAT:  bus_rdata = {31'b0, !rx_empty};
                OFS_IEN:   bus_rdata = flags_to_word(ien, 1'b0);
                OFS_IFLAG: bus_rdata = flags_to_word(flags, level_hit);
                OFS_FCTL: begin
                    bus_rdata[8 +: THR_W] = tx_thr;
                    bus_rdata[0 +: THR_W] = rx_thr;
                end
                OFS_DATA:  bus_rdata = rx_head;
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R12
    enable_write_keeps_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CTRL) |=> ($stable(cfg_clock) && $stable(cfg_frame)));
    // R3
    full_tx_write_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_at_data && tx_full && !tx_flush && !(eng_tx_take && eng_tx_valid)) |=> $stable(tx_count));
    // R6
    rx_flush_status_chk: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> rx_empty);

endmodule

// File: tb/spi_regfront_test.sv
module spi_regfront_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 0, bus_rd = 0;
    logic [5:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        eng_enable, eng_tx_valid, irq;
    logic [31:0] eng_tx_word;
    logic        eng_tx_take = 0, eng_rx_valid = 0, eng_tx_done = 0;
    logic [31:0] eng_rx_word = 0;
    logic [15:0] cfg_clock, cfg_frame;
    logic [13:0] cfg_txword;
    logic [5:0]  cfg_rxword;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    spi_regfront uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_enable(eng_enable), .eng_tx_valid(eng_tx_valid), .eng_tx_word(eng_tx_word),
        .eng_tx_take(eng_tx_take), .eng_rx_valid(eng_rx_valid), .eng_rx_word(eng_rx_word),
        .eng_tx_done(eng_tx_done), .cfg_clock(cfg_clock), .cfg_txword(cfg_txword),
        .cfg_rxword(cfg_rxword), .cfg_frame(cfg_frame), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] keep_mask(input logic [5:0] a);
        case (a)
            6'h04: return 32'h0000_70FF;
            6'h08: return 32'h0000_3FFF;
            6'h0C: return 32'h0000_003F;
            6'h10: return 32'h0000_C000;
            6'h18: return 32'h0000_0019;
            default: return 32'h0;
        endcase
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 bus_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #2 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 0;
    endtask

    task automatic eng_send(input logic [31:0] w);
        @(negedge clk);
        eng_rx_valid = 1; eng_rx_word = w;
        @(posedge clk); #1 eng_rx_valid = 0;
    endtask

    task automatic eng_pull(output logic v, output logic [31:0] w);
        @(negedge clk);
        #2 v = eng_tx_valid; w = eng_tx_word;
        eng_tx_take = 1;
        @(posedge clk); #1 eng_tx_take = 0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d, w;
        logic v;
        logic [31:0] words [9];
        logic [5:0]  cfgs [5];
        void'($urandom(32'd2024));
        cfgs[0] = 6'h04; cfgs[1] = 6'h08; cfgs[2] = 6'h0C; cfgs[3] = 6'h10; cfgs[4] = 6'h18;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        for (int i = 0; i <= 9; i++) begin
            rd(6'(i*4), d);
            chk("R1 reg reset", d, 32'h0);
        end
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 enable", {31'b0, eng_enable}, 0);
        chk("R1 tx_valid", {31'b0, eng_tx_valid}, 0);

        // R2 random setup values
        for (int k = 0; k < 4; k++) begin
            foreach (cfgs[j]) begin
                logic [31:0] val;
                val = $urandom;
                wr(cfgs[j], val);
                rd(cfgs[j], d);
                chk("R2 readback", d, val & keep_mask(cfgs[j]));
                if (cfgs[j] == 6'h04) chk("R2 cfg_clock", {16'b0, cfg_clock}, val & 32'h70FF);
                if (cfgs[j] == 6'h08) chk("R2 cfg_txword", {18'b0, cfg_txword}, val & 32'h3FFF);
                if (cfgs[j] == 6'h0C) chk("R2 cfg_rxword", {26'b0, cfg_rxword}, val & 32'h3F);
                if (cfgs[j] == 6'h10) chk("R2 cfg_frame", {16'b0, cfg_frame}, val & 32'hC000);
            end
        end
        wr(6'h18, 0);
        rd(6'h2C, d);
        chk("R2 unmapped", d, 0);

        // R12 enable
        wr(6'h00, 1);
        chk("R12 enable on", {31'b0, eng_enable}, 1);

        // R3 push 9, one dropped
        foreach (words[i]) begin
            words[i] = $urandom;
            wr(6'h24, words[i]);
        end
        for (int i = 0; i < 8; i++) begin
            eng_pull(v, w);
            chk("R3 tx valid", {31'b0, v}, 1);
            chk("R3 tx order", w, words[i]);
        end
        @(negedge clk);
        chk("R3 ninth dropped", {31'b0, eng_tx_valid}, 0);

        // R12 valid gated by enable, contents kept
        wr(6'h00, 0);
        wr(6'h24, 32'hCAFE_0001);
        @(negedge clk);
        chk("R12 valid gated", {31'b0, eng_tx_valid}, 0);
        wr(6'h00, 1);
        @(negedge clk);
        chk("R12 word kept", eng_tx_word, 32'hCAFE_0001);
        chk("R12 valid back", {31'b0, eng_tx_valid}, 1);
        // R6 tx flush
        wr(6'h20, 32'h0000_1000);
        @(negedge clk);
        chk("R6 tx flushed", {31'b0, eng_tx_valid}, 0);

        // R9, R11, R10 tx-complete
        @(negedge clk); eng_tx_done = 1; @(posedge clk); #1 eng_tx_done = 0;
        rd(6'h1C, d);
        chk("R9 txdone flag", d, 32'h10);
        chk("R11 masked", {31'b0, irq}, 0);
        wr(6'h18, 32'h10);
        @(negedge clk);
        chk("R11 irq on", {31'b0, irq}, 1);
        wr(6'h1C, 32'h0000_0009);
        rd(6'h1C, d);
        chk("R10 other bits no effect", d, 32'h10);
        wr(6'h1C, 32'h10);
        rd(6'h1C, d);
        chk("R10 cleared", d, 0);
        chk("R11 irq off", {31'b0, irq}, 0);

        // R10 set wins over clear
        @(negedge clk);
        eng_tx_done = 1; bus_wr = 1; bus_addr = 6'h1C; bus_wdata = 32'h10;
        @(posedge clk); #1 eng_tx_done = 0; bus_wr = 0;
        rd(6'h1C, d);
        chk("R10 set wins", d, 32'h10);
        wr(6'h1C, 32'h10);
        wr(6'h18, 0);

        // R6 thresholds, R7 receive level
        wr(6'h20, 32'h0000_0503);
        rd(6'h20, d);
        chk("R6 thresholds", d, 32'h0503);
        for (int i = 0; i < 3; i++) words[i] = $urandom;
        eng_send(words[0]);
        eng_send(words[1]);
        rd(6'h1C, d);
        chk("R7 below level", d, 0);
        eng_send(words[2]);
        rd(6'h1C, d);
        chk("R7 level reached", d, 32'h208);
        wr(6'h18, 32'h08);
        @(negedge clk);
        chk("R11 rx irq", {31'b0, irq}, 1);
        rd(6'h14, d);
        chk("R5 not empty", d, 1);
        for (int i = 0; i < 3; i++) begin
            rd(6'h24, d);
            chk("R4 rx order", d, words[i]);
        end
        rd(6'h14, d);
        chk("R5 empty", d, 0);
        rd(6'h24, d);
        chk("R4 empty read", d, 0);
        rd(6'h1C, d);
        chk("R7 flag sticky, level gone", d, 32'h08);
        wr(6'h1C, 32'h08);
        wr(6'h18, 0);

        // R8 overrun
        wr(6'h20, 0);
        foreach (words[i]) begin
            words[i] = $urandom;
            eng_send(words[i]);
        end
        rd(6'h1C, d);
        chk("R8 overrun flag", d, 32'h01);
        wr(6'h1C, 0);
        rd(6'h1C, d);
        chk("R10 zero write", d, 32'h01);
        for (int i = 0; i < 8; i++) begin
            rd(6'h24, d);
            chk("R8 kept words", d, words[i]);
        end
        rd(6'h14, d);
        chk("R8 ninth gone", d, 0);
        wr(6'h1C, 32'h01);
        rd(6'h1C, d);
        chk("R10 ovr cleared", d, 0);

        // R6 rx flush
        eng_send(32'h1234_5678);
        eng_send(32'h9ABC_DEF0);
        wr(6'h20, 32'h0000_0010);
        rd(6'h14, d);
        chk("R6 rx flushed", d, 0);
        rd(6'h20, d);
        chk("R6 flush bits not stored", d, 0);

        // R12 disable keeps setup
        wr(6'h04, 32'h0000_10AA);
        wr(6'h00, 0);
        chk("R12 enable off", {31'b0, eng_enable}, 0);
        rd(6'h04, d);
        chk("R12 setup kept", d, 32'h10AA);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule